// File: doc/BRIEF.md
# Tagged Character FIFO Pair with Bus Wait Handshake

This block sits between a processor-style synchronous bus and a serial engine. It holds two 16-entry character queues. The receive queue is filled by the engine and drained by bus reads. The transmit queue is filled by bus writes and drained by the engine. Every receive entry keeps its data byte together with a small status tag. Every transmit entry keeps its byte together with a command tag. The bus reads and writes the tag alongside the byte.

Bus strobes are active low and count only while chip select is low. A read takes effect at the strobe's leading edge. A write is captured when the write strobe rises. An access that cannot complete (a read with no receive entry, or a write with no transmit space) can stall the bus through an active-low ready output, but only in the wait modes that cover that direction. Two fill-level requests compare the queue occupancies against 4-bit thresholds. A flow-stop output tells the remote sender to pause while the receive queue is full.

Top module: `tag_fifo_bus`

## Requirements
- R1: After reset both queues are empty: `rdy_n`=1, `flow_stop`=0, `rx_irq`=0, `tx_irq`=1, `tx_empty`=1, and `rd_data` and `rd_stat` are 0.
- R2: Bus reads return receive entries in push order. Each read returns both `rd_data` and `rd_stat`, and they are valid from the first clock edge that sees the read strobe active.
- R3: With `cs_n` high, `rd_n` and `wr_n` have no effect: no entry is consumed and none is written.
- R4: A write is captured on the clock edge that sees the write strobe go inactive. While the strobe is held low, the transmit queue is unchanged.
- R5: The engine sees transmit entries in write order on `tx_data` and `tx_cmd`. `tx_empty` is 1 once all entries have been popped.
- R6: `wait_mode` bit 0 enables waiting on receive, and bit 1 enables waiting on transmit. A read leading edge on an empty receive queue with bit 0 set drives `rdy_n` low from the next clock. The same holds for a write leading edge on a full transmit queue with bit 1 set.
- R7: `rdy_n` stays 1 for any access whose direction bit in `wait_mode` is 0 (in particular `wait_mode`=00).
- R8: A stalled read holds `rdy_n` low while the receive queue is empty. Once an entry arrives, `rdy_n` returns to 1 and `rd_data` and `rd_stat` hold that entry one clock after the occupancy becomes non-zero.
- R9: A stalled write releases `rdy_n` one clock after the transmit queue becomes non-full. The held data is then queued behind the existing entries when the strobe rises.
- R10: A read on an empty receive queue with no wait leaves `rd_data` and `rd_stat` at their last values, and the queue does not underflow.
- R11: A write to a full transmit queue with no wait is dropped, and the queue contents are unchanged.
- R12: `rx_irq` is 1 exactly when the receive occupancy is greater than `rx_thresh`. `tx_irq` is 1 exactly when the transmit occupancy is less than or equal to `tx_thresh`.
- R13: `flow_stop` is 1 exactly when the receive queue holds 16 entries. An engine push into a full receive queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wr_data | input | DATA_W | Byte written to the transmit queue |
| wr_cmd | input | CMD_W | Command tag written with the byte |
| rd_data | output | DATA_W | Byte of the last receive entry read |
| rd_stat | output | STAT_W | Status tag of the last receive entry read |
| rdy_n | output | 1 | Ready, low while an access is stalled |
| wait_mode | input | 2 | Bit 0 waits on receive, bit 1 waits on transmit |
| rx_thresh | input | 4 | Receive fill-level threshold |
| tx_thresh | input | 4 | Transmit fill-level threshold |
| rx_irq | output | 1 | Receive fill-level request |
| tx_irq | output | 1 | Transmit fill-level request |
| flow_stop | output | 1 | Receive queue full, remote sender should stop |
| rx_push | input | 1 | Engine pushes a receive entry |
| rx_push_data | input | DATA_W | Received byte |
| rx_push_stat | input | STAT_W | Status tag of the received byte |
| tx_pop | input | 1 | Engine pops the transmit head |
| tx_data | output | DATA_W | Transmit head byte |
| tx_cmd | output | CMD_W | Transmit head command tag |
| tx_empty | output | 1 | Transmit queue empty |

## Verification
Read data, occupancy-driven outputs and the ready line each change on the first clock edge after their cause. The bench drives inputs at falling edges and samples at the next falling edge, so each result is checked exactly one edge after its stimulus. A stalled read or write is held across several clocks, and `rdy_n` is checked both on the clock where the queue first changes and on the clock after. That pins the one-clock release of R8 and R9. A sweep over all sixteen thresholds and all seventeen fill levels recomputes both requests and the flow-stop level arithmetically, and it verifies tag and data order as the queues drain.

// File: rtl/tagfifo_pkg.sv
package tagfifo_pkg;
  localparam int FIFO_DEPTH = 16;
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int THR_W = PTR_W;

  typedef enum logic [1:0] {
    WAIT_OFF = 2'b00,
    WAIT_RX  = 2'b01,
    WAIT_TX  = 2'b10,
    WAIT_ANY = 2'b11
  } wait_mode_e;

  // receive request: occupancy above threshold
  function automatic logic rx_level_req(input logic [CNT_W-1:0] cnt,
                                        input logic [THR_W-1:0] thr);
    return cnt > {1'b0, thr};
  endfunction

  // transmit request: occupancy at or below threshold
  function automatic logic tx_level_req(input logic [CNT_W-1:0] cnt,
                                        input logic [THR_W-1:0] thr);
    return cnt <= {1'b0, thr};
  endfunction

  function automatic logic waits_on_rx(input wait_mode_e m);
    return m[0];
  endfunction

  function automatic logic waits_on_tx(input wait_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/tagfifo_store.sv
module tagfifo_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WIDTH-1:0]           push_word,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head_word,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign count   = cnt;
  assign head_word = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= ptr_next(wp);
      if (pop_ok)  rp <= ptr_next(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
  a_r11_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tagfifo_strobe.sv
module tagfifo_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic strobe_n,
  output logic active,
  output logic lead,
  output logic trail
);
  logic active_q;

  assign active = ~cs_n & ~strobe_n;
  assign lead   = active & ~active_q;
  assign trail  = active_q & ~active;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active;
  end
endmodule

// File: rtl/tag_fifo_bus.sv
module tag_fifo_bus
  import tagfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAT_W = 3,
  parameter int CMD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CMD_W-1:0]  wr_cmd,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] rd_stat,
  output logic              rdy_n,
  input  logic [1:0]        wait_mode,
  input  logic [THR_W-1:0]  rx_thresh,
  input  logic [THR_W-1:0]  tx_thresh,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              flow_stop,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic [STAT_W-1:0] rx_push_stat,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_data,
  output logic [CMD_W-1:0]  tx_cmd,
  output logic              tx_empty
);
  localparam int RXW = DATA_W + STAT_W;
  localparam int TXW = DATA_W + CMD_W;

  wait_mode_e mode;
  assign mode = wait_mode_e'(wait_mode);

  // bus strobe events
  logic rd_act, rd_lead, rd_trail;
  logic wr_act, wr_lead, wr_trail;

  tagfifo_strobe u_rd_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strobe_n(rd_n),
    .active(rd_act), .lead(rd_lead), .trail(rd_trail)
  );
  tagfifo_strobe u_wr_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strobe_n(wr_n),
    .active(wr_act), .lead(wr_lead), .trail(wr_trail)
  );

  // receive queue
  logic [RXW-1:0]   rx_head;
  logic [CNT_W-1:0] rx_count;
  logic             rx_full, rx_empty, rx_pop;
  logic             rd_pend;

  assign rx_pop = ~rx_empty & (rd_lead | (rd_pend & rd_act));

  tagfifo_store #(.WIDTH(RXW), .DEPTH(FIFO_DEPTH)) u_rx_store (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_word({rx_push_stat, rx_push_data}),
    .pop(rx_pop), .head_word(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  // transmit queue
  logic [TXW-1:0]   tx_head;
  logic [CNT_W-1:0] tx_count;
  logic             tx_full;
  logic             wr_pend;

  tagfifo_store #(.WIDTH(TXW), .DEPTH(FIFO_DEPTH)) u_tx_store (
    .clk(clk), .rst_n(rst_n),
    .push(wr_trail), .push_word({wr_cmd, wr_data}),
    .pop(tx_pop), .head_word(tx_head),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  assign {tx_cmd, tx_data} = tx_head;

  // stall flags: set at the leading edge, kept while the access is blocked
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      rd_pend <= rd_act & waits_on_rx(mode) & rx_empty & (rd_lead | rd_pend);
      wr_pend <= wr_act & waits_on_tx(mode) & tx_full & (wr_lead | wr_pend);
    end
  end

  assign rdy_n = ~(rd_pend | wr_pend);

  // read data register holds the last entry taken
  always_ff @(posedge clk) begin
    if (!rst_n)      {rd_stat, rd_data} <= '0;
    else if (rx_pop) {rd_stat, rd_data} <= rx_head;
  end

  assign rx_irq    = rx_level_req(rx_count, rx_thresh);
  assign tx_irq    = tx_level_req(tx_count, tx_thresh);
  assign flow_stop = rx_full;

  a_r7_no_wait_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WAIT_OFF) |=> rdy_n);
  a_r6_read_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lead && rx_empty && waits_on_rx(mode)) |=> !rdy_n);
  a_r6_write_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lead && tx_full && waits_on_tx(mode)) |=> !rdy_n);
  a_r8_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && rd_act && !rx_empty) |=> !rd_pend);
  a_r8_abandon_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_trail |=> !rd_pend);
  a_r10_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lead && rx_empty && !waits_on_rx(mode)) |=> $stable(rd_data));
  a_r13_flow_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_stop && rx_push && !rx_pop) |=> flow_stop);
endmodule

// File: tb/tag_fifo_bus_tb.sv
module tag_fifo_bus_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, rd_n, wr_n;
  logic [7:0] wr_data, rd_data, rx_push_data, tx_data;
  logic [1:0] wr_cmd, tx_cmd, wait_mode;
  logic [2:0] rd_stat, rx_push_stat;
  logic [3:0] rx_thresh, tx_thresh;
  logic       rdy_n, rx_irq, tx_irq, flow_stop, rx_push, tx_pop, tx_empty;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  tag_fifo_bus u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .wr_data(wr_data), .wr_cmd(wr_cmd), .rd_data(rd_data), .rd_stat(rd_stat),
    .rdy_n(rdy_n), .wait_mode(wait_mode), .rx_thresh(rx_thresh),
    .tx_thresh(tx_thresh), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .flow_stop(flow_stop), .rx_push(rx_push), .rx_push_data(rx_push_data),
    .rx_push_stat(rx_push_stat), .tx_pop(tx_pop), .tx_data(tx_data),
    .tx_cmd(tx_cmd), .tx_empty(tx_empty)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int t, input int l);
    return 8'((t * 17 + l * 5 + 1) % 256);
  endfunction

  task automatic bus_read(output logic [7:0] d, output logic [2:0] s);
    @(negedge clk); cs_n = 0; rd_n = 0;
    @(negedge clk); d = rd_data; s = rd_stat; cs_n = 1; rd_n = 1;
  endtask

  task automatic bus_write(input logic [7:0] d, input logic [1:0] c);
    @(negedge clk); wr_data = d; wr_cmd = c; cs_n = 0; wr_n = 0;
    @(negedge clk); cs_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  task automatic eng_push(input logic [7:0] d, input logic [2:0] s);
    @(negedge clk); rx_push = 1; rx_push_data = d; rx_push_stat = s;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic eng_pop(output logic [7:0] d, output logic [1:0] c);
    @(negedge clk); d = tx_data; c = tx_cmd; tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [2:0] s;
    logic [1:0] c;
    logic [7:0] last_rd;
    rst_n = 0; cs_n = 1; rd_n = 1; wr_n = 1; wr_data = 0; wr_cmd = 0;
    wait_mode = 2'b00; rx_thresh = 0; tx_thresh = 0;
    rx_push = 0; rx_push_data = 0; rx_push_stat = 0; tx_pop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdy_n", rdy_n, 1);
    check("R1 flow_stop", flow_stop, 0);
    check("R1 rx_irq", rx_irq, 0);
    check("R1 tx_irq", tx_irq, 1);
    check("R1 tx_empty", tx_empty, 1);
    check("R1 rd_data", rd_data, 0);
    check("R1 rd_stat", rd_stat, 0);

    // R12/R13/R2/R5 sweep over every threshold and fill level
    for (int t = 0; t < 16; t++) begin
      @(negedge clk); rx_thresh = 4'(t); tx_thresh = 4'(t);
      @(negedge clk);
      for (int l = 0; l <= 16; l++) begin
        check($sformatf("R12 rx_irq thr=%0d lvl=%0d", t, l), rx_irq, (l > t) ? 1 : 0);
        check($sformatf("R12 tx_irq thr=%0d lvl=%0d", t, l), tx_irq, (l <= t) ? 1 : 0);
        check($sformatf("R13 flow_stop lvl=%0d", l), flow_stop, (l == 16) ? 1 : 0);
        if (l < 16) begin
          eng_push(pat(t, l), 3'(l % 8));
          bus_write(pat(t, l), 2'(l % 4));
        end
      end
      eng_push(8'hFF, 3'd7);
      check("R13 flow_stop after extra push", flow_stop, 1);
      for (int i = 0; i < 16; i++) begin
        bus_read(d, s);
        check($sformatf("R2 rd_data thr=%0d idx=%0d", t, i), d, pat(t, i));
        check($sformatf("R2 rd_stat idx=%0d", i), s, i % 8);
        eng_pop(d, c);
        check($sformatf("R5 tx_data thr=%0d idx=%0d", t, i), d, pat(t, i));
        check($sformatf("R5 tx_cmd idx=%0d", i), c, i % 4);
      end
      @(negedge clk);
      check("R5 tx_empty after drain", tx_empty, 1);
      check("R13 flow_stop after drain", flow_stop, 0);
    end
    last_rd = pat(15, 15);

    // R3 strobes ignored without chip select
    eng_push(8'h33, 3'd1);
    @(negedge clk); cs_n = 1; rd_n = 0;
    @(negedge clk);
    @(negedge clk); rd_n = 1;
    check("R3 rd_data unchanged", rd_data, last_rd);
    @(negedge clk); wr_data = 8'h99; wr_n = 0;
    @(negedge clk);
    @(negedge clk); wr_n = 1;
    @(negedge clk);
    check("R3 tx_empty after write without cs", tx_empty, 1);
    bus_read(d, s);
    check("R3 entry kept data", d, 8'h33);
    check("R3 entry kept stat", s, 1);

    // R4 write captured at strobe rise
    @(negedge clk); wr_data = 8'h44; wr_cmd = 2'd2; cs_n = 0; wr_n = 0;
    @(negedge clk);
    check("R4 tx_empty while strobe low", tx_empty, 1);
    @(negedge clk);
    check("R4 tx_empty still low strobe", tx_empty, 1);
    cs_n = 1; wr_n = 1;
    @(negedge clk);
    check("R4 tx_empty after rise", tx_empty, 0);
    check("R4 tx_data", tx_data, 8'h44);
    check("R4 tx_cmd", tx_cmd, 2);
    eng_pop(d, c);

    // R7/R10 empty reads without wait
    @(negedge clk); wait_mode = 2'b00; rx_thresh = 0;
    @(negedge clk); cs_n = 0; rd_n = 0;
    @(negedge clk);
    check("R7 rdy_n mode off", rdy_n, 1);
    @(negedge clk);
    check("R10 rd_data held", rd_data, 8'h33);
    check("R10 rd_stat held", rd_stat, 1);
    cs_n = 1; rd_n = 1;
    @(negedge clk); wait_mode = 2'b10;
    @(negedge clk); cs_n = 0; rd_n = 0;
    @(negedge clk);
    check("R7 rdy_n tx-only mode read", rdy_n, 1);
    cs_n = 1; rd_n = 1;
    eng_push(8'h5A, 3'd5);
    bus_read(d, s);
    check("R10 no underflow data", d, 8'h5A);
    check("R10 no underflow stat", s, 5);
    @(negedge clk);
    check("R10 rx empty again", rx_irq, 0);

    // R6/R8 stalled read
    wait_mode = 2'b01;
    @(negedge clk); cs_n = 0; rd_n = 0;
    @(negedge clk);
    check("R6 rdy_n low on empty read", rdy_n, 0);
    repeat (3) @(negedge clk);
    check("R8 rdy_n held while empty", rdy_n, 0);
    rx_push = 1; rx_push_data = 8'h6C; rx_push_stat = 3'd3;
    @(negedge clk); rx_push = 0;
    check("R8 rdy_n on push clock", rdy_n, 0);
    @(negedge clk);
    check("R8 rdy_n released", rdy_n, 1);
    check("R8 rd_data", rd_data, 8'h6C);
    check("R8 rd_stat", rd_stat, 3);
    cs_n = 1; rd_n = 1;
    @(negedge clk);
    check("R8 rx drained", rx_irq, 0);

    // R6/R9 stalled write
    wait_mode = 2'b11;
    for (int i = 0; i < 16; i++) bus_write(8'(8'h80 + i), 2'(i % 4));
    @(negedge clk); wr_data = 8'hC9; wr_cmd = 2'd1; cs_n = 0; wr_n = 0;
    @(negedge clk);
    check("R6 rdy_n low on full write", rdy_n, 0);
    d = tx_data; tx_pop = 1;
    @(negedge clk); tx_pop = 0;
    check("R9 first pop data", d, 8'h80);
    check("R9 rdy_n on pop clock", rdy_n, 0);
    @(negedge clk);
    check("R9 rdy_n released", rdy_n, 1);
    cs_n = 1; wr_n = 1;
    @(negedge clk);
    for (int i = 1; i < 16; i++) begin
      eng_pop(d, c);
      check($sformatf("R9 drain idx=%0d", i), d, 8'h80 + i);
    end
    eng_pop(d, c);
    check("R9 stalled data queued last", d, 8'hC9);
    check("R9 stalled cmd", c, 1);

    // R11/R7 write to full without transmit wait
    wait_mode = 2'b01;
    for (int i = 0; i < 16; i++) bus_write(8'(8'h40 + i), 2'(i % 4));
    @(negedge clk); wr_data = 8'hEE; wr_cmd = 2'd3; cs_n = 0; wr_n = 0;
    @(negedge clk);
    check("R7 rdy_n rx-only mode write", rdy_n, 1);
    cs_n = 1; wr_n = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      eng_pop(d, c);
      check($sformatf("R11 contents idx=%0d", i), d, 8'h40 + i);
    end
    @(negedge clk);
    check("R11 dropped write", tx_empty, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule